// File: doc/BRIEF.md
# Dual-Chain Carry-Select Adder/Subtractor

This block is a ten-bit adder/subtractor built as a row of identical bit-cells. Each cell works out its sum bit and its carry twice, in parallel: once as if the slice carry-in were 0 and once as if it were 1. Two carry chains therefore ripple side by side through the whole slice. Neither chain waits for the real carry-in. The carry-in arrives at the slice edge and only drives a final row of selectors, which pick one chain's sum bits and final carry.

A single mode input switches every cell between addition and subtraction on any cycle. In subtract mode the second operand is inverted on its way into the cells. The mode input also forces the low-order carry to 1, so the slice forms A + ~B + 1. The slice reports a carry-out and a two's-complement overflow flag with the result. An output register with enable and synchronous clear is fitted by default. A parameter removes it for purely combinational use.

Top module: `dualchain_addsub`

## Requirements
- R1: With `sub_mode`=0, the result is (`opd_a` + `opd_b` + `carry_in`) mod 2^10.
- R2: With `sub_mode`=1, the result is (`opd_a` − `opd_b`) mod 2^10, and `carry_in` has no effect on the result or on either flag.
- R3: `carry_out` is bit 10 of the full unsigned sum. In add mode this is bit 10 of `opd_a`+`opd_b`+`carry_in`. In subtract mode it is 1 exactly when `opd_a` ≥ `opd_b` as unsigned numbers.
- R4: `ovfl` is 1 exactly when the true two's-complement result (A+B+cin or A−B, with operands read as signed 10-bit values) lies outside −512..511.
- R5: While `rst_n` is low, `res`, `carry_out` and `ovfl` are all 0 at the next rising edge.
- R6: With the output register fitted, `clr`=1 at a rising edge sets all three outputs to 0, whatever `en` is.
- R7: With the output register fitted, `en`=0 and `clr`=0 at a rising edge leave all three outputs unchanged.
- R8: With the output register fitted, the outputs show the result of the operands and controls present at the previous rising edge. The mode may change on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| opd_a | input | 10 | First operand |
| opd_b | input | 10 | Second operand (subtrahend in subtract mode) |
| carry_in | input | 1 | Slice carry-in; selects the chain in add mode |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| en | input | 1 | Output register load enable |
| clr | input | 1 | Output register synchronous clear |
| res | output | 10 | Result |
| carry_out | output | 1 | Carry out of bit 9 of the selected chain |
| ovfl | output | 1 | Signed overflow |

## Verification
The bench targets the operand pairs that stress the top bit: 511+1, −512−1, 0−1 and all-ones plus all-ones with carry-in. A design that picks the wrong chain there, or that takes overflow from the carry out of bit 8, gives a wrong `ovfl` or a result that is one off. Subtract cases are run with `carry_in` at both values, because a slice that lets the carry-in leak through in subtract mode returns A−B−1 or A−B+1. Mode flips on consecutive cycles, clear with enable high, and hold with enable low show whether the register gets its priority or its latency wrong.

// File: rtl/addsub_pkg.sv
// Package: shared types for the dual-chain adder/subtractor.
package addsub_pkg;
    // Arithmetic mode chosen at run time by the shared control input.
    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } arith_mode_e;

    // Flags that travel with each result.
    typedef struct packed {
        logic co;
        logic ov;
    } flags_t;
endpackage

// File: rtl/addsub_cell.sv
// Module: addsub_cell
// One bit-cell carrying two carry chains. Chain 0 assumes the slice carry-in
// was 0 and chain 1 assumes it was 1. The cell makes one sum bit and one
// carry per chain. It assumes the operand B bit has already been inverted
// for subtraction.
module addsub_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c0_i,
    input  logic c1_i,
    output logic s0_o,
    output logic s1_o,
    output logic c0_o,
    output logic c1_o
);
    logic prop;
    logic gen;

    // Propagate and generate terms, shared by both chains.
    always_comb begin
        prop = a_i ^ b_i;
        gen  = a_i & b_i;
    end

    // Sum and carry for each assumed chain.
    always_comb begin
        s0_o = prop ^ c0_i;
        s1_o = prop ^ c1_i;
        c0_o = gen | (prop & c0_i);
        c1_o = gen | (prop & c1_i);
    end
endmodule

// File: rtl/addsub_chain.sv
// Module: addsub_chain
// A row of W bit-cells with both carry chains threaded through. Chain 0 enters
// with 0 and chain 1 enters with 1. The late select input then picks one chain's
// sums, its final carry and the carry that went into the top bit. The module
// assumes W >= 2.
module addsub_chain #(
    parameter int W = 10
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cmsb_o
);
    logic [W:0]   ch0;
    logic [W:0]   ch1;
    logic [W-1:0] s0;
    logic [W-1:0] s1;

    assign ch0[0] = 1'b0;
    assign ch1[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_cell
            addsub_cell u_cell (
                .a_i  (a_i[gi]),
                .b_i  (b_i[gi]),
                .c0_i (ch0[gi]),
                .c1_i (ch1[gi]),
                .s0_o (s0[gi]),
                .s1_o (s1[gi]),
                .c0_o (ch0[gi+1]),
                .c1_o (ch1[gi+1])
            );
        end
    endgenerate

    // Late select: the real slice carry picks one chain.
    always_comb begin
        sum_o  = sel_i ? s1        : s0;
        cout_o = sel_i ? ch1[W]    : ch0[W];
        cmsb_o = sel_i ? ch1[W-1]  : ch0[W-1];
    end
endmodule

// File: rtl/addsub_outstage.sv
// Module: addsub_outstage
// Output stage. With REG_OUT=1 it is a register with synchronous active-low
// reset, synchronous clear (clear wins over enable) and load enable. With
// REG_OUT=0 it passes its input straight through and ignores the clock controls.
module addsub_outstage #(
    parameter int W       = 10,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  clr_i,
    input  logic [W-1:0]          d_i,
    input  addsub_pkg::flags_t    f_i,
    output logic [W-1:0]          q_o,
    output addsub_pkg::flags_t    f_o
);
    generate
        if (REG_OUT) begin : g_reg
            logic [W-1:0]       q_r;
            addsub_pkg::flags_t f_r;

            // Register the result and flags: reset, clear, then load.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    q_r <= '0;
                    f_r <= '0;
                end else if (en_i) begin
                    q_r <= d_i;
                    f_r <= f_i;
                end
            end
            assign q_o = q_r;
            assign f_o = f_r;
        end else begin : g_bypass
            logic unused_ctl;
            assign unused_ctl = &{1'b0, clk, rst_n, en_i, clr_i};
            assign q_o = d_i;
            assign f_o = f_i;
        end
    endgenerate
endmodule

// File: rtl/dualchain_addsub.sv
// Module: dualchain_addsub
// Top of the adder/subtractor. In subtract mode it inverts operand B and forces
// the slice carry to 1, so carry_in is ignored. In add mode carry_in selects the
// chain. Overflow is the XOR of the carries into and out of the top bit of the
// selected chain. The output stage is chosen by REG_OUT.
module dualchain_addsub #(
    parameter int W       = 10,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opd_a,
    input  logic [W-1:0] opd_b,
    input  logic         carry_in,
    input  logic         sub_mode,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] res,
    output logic         carry_out,
    output logic         ovfl
);
    import addsub_pkg::*;

    arith_mode_e  mode;
    logic [W-1:0] b_eff;
    logic         sel;
    logic [W-1:0] sum_c;
    logic         cout_c;
    logic         cmsb_c;
    flags_t       flags_c;
    flags_t       flags_q;

    // Operand conditioning and late chain select from the shared mode control.
    always_comb begin
        mode  = arith_mode_e'(sub_mode);
        b_eff = (mode == MODE_SUB) ? ~opd_b : opd_b;
        sel   = (mode == MODE_SUB) ? 1'b1   : carry_in;
    end

    addsub_chain #(.W(W)) u_chain (
        .a_i    (opd_a),
        .b_i    (b_eff),
        .sel_i  (sel),
        .sum_o  (sum_c),
        .cout_o (cout_c),
        .cmsb_o (cmsb_c)
    );

    // Flag formation from the selected chain.
    always_comb begin
        flags_c.co = cout_c;
        flags_c.ov = cout_c ^ cmsb_c;
    end

    addsub_outstage #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en),
        .clr_i (clr),
        .d_i   (sum_c),
        .f_i   (flags_c),
        .q_o   (res),
        .f_o   (flags_q)
    );

    assign carry_out = flags_q.co;
    assign ovfl      = flags_q.ov;
endmodule

// File: rtl/dualchain_addsub_chk.sv
// Module: dualchain_addsub_chk
// Checker for dualchain_addsub. The properties apply only when the output
// register is fitted, and each one relates the ports across one clock edge.
module dualchain_addsub_chk #(
    parameter int W       = 10,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opd_a,
    input logic [W-1:0] opd_b,
    input logic         carry_in,
    input logic         sub_mode,
    input logic         en,
    input logic         clr,
    input logic [W-1:0] res,
    input logic         carry_out,
    input logic         ovfl
);
    logic [W-1:0] want_add;
    logic [W-1:0] want_sub;
    logic         load;

    // Independent arithmetic for the expected values.
    always_comb begin
        want_add = opd_a + opd_b + {{(W-1){1'b0}}, carry_in};
        want_sub = opd_a - opd_b;
        load     = en && !clr;
    end

    generate
        if (REG_OUT) begin : g_props
            // R1
            add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && !sub_mode) |=> (res == $past(want_add)));
            // R2
            sub_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && sub_mode) |=> (res == $past(want_sub)));
            // R3
            no_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && sub_mode) |=> (carry_out == $past(opd_a >= opd_b)));
            // R4
            same_sign_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && !sub_mode && (opd_a[W-1] == opd_b[W-1]))
                |=> (ovfl == (res[W-1] != $past(opd_a[W-1]))));
            // R4
            mixed_sign_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (load && !sub_mode && (opd_a[W-1] != opd_b[W-1])) |=> !ovfl);
            // R6
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> (res == '0 && !carry_out && !ovfl));
            // R7
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!en && !clr) |=> ($stable(res) && $stable(carry_out) && $stable(ovfl)));
        end
    endgenerate
endmodule

bind dualchain_addsub dualchain_addsub_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .carry_in  (carry_in),
    .sub_mode  (sub_mode),
    .en        (en),
    .clr       (clr),
    .res       (res),
    .carry_out (carry_out),
    .ovfl      (ovfl)
);

// File: tb/sim_dualchain_addsub.sv
module sim_dualchain_addsub;
    localparam int W    = 10;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] opd_a, opd_b;
    logic         carry_in, sub_mode, en, clr;
    logic [W-1:0] res;
    logic         carry_out, ovfl;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state, updated once per clock.
    int m_res = 0;
    int m_co  = 0;
    int m_ov  = 0;

    always #2.5 clk = ~clk;

    dualchain_addsub u0 (
        .clk(clk), .rst_n(rst_n), .opd_a(opd_a), .opd_b(opd_b),
        .carry_in(carry_in), .sub_mode(sub_mode), .en(en), .clr(clr),
        .res(res), .carry_out(carry_out), .ovfl(ovfl)
    );

    function automatic int to_signed(int v);
        return (v >= (1 << (W-1))) ? v - (1 << W) : v;
    endfunction

    task automatic check(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model and compare after the edge.
    task automatic step(int a, int b, bit ci, bit sb, bit e, bit c, string req);
        int full, sres;
        opd_a = W'(a); opd_b = W'(b); carry_in = ci; sub_mode = sb; en = e; clr = c;
        if (c) begin
            m_res = 0; m_co = 0; m_ov = 0;
        end else if (e) begin
            if (sb) begin
                full = a + ((~b) & MASK) + 1;
                sres = to_signed(a) - to_signed(b);
            end else begin
                full = a + b + int'(ci);
                sres = to_signed(a) + to_signed(b) + int'(ci);
            end
            m_res = full & MASK;
            m_co  = (full >> W) & 1;
            m_ov  = (sres > (1 << (W-1)) - 1 || sres < -(1 << (W-1))) ? 1 : 0;
        end
        @(negedge clk);
        check(req, "res",       int'(res),       m_res);
        check(req, "carry_out", int'(carry_out), m_co);
        check(req, "ovfl",      int'(ovfl),      m_ov);
    endtask

    initial begin
        rst_n = 1'b0; opd_a = '1; opd_b = '1; carry_in = 1'b1; sub_mode = 1'b0;
        en = 1'b1; clr = 1'b0;
        repeat (3) @(negedge clk);
        // R5: reset forces zero outputs
        check("R5", "res",       int'(res),       0);
        check("R5", "carry_out", int'(carry_out), 0);
        check("R5", "ovfl",      int'(ovfl),      0);
        rst_n = 1'b1;

        // R1 R3 R4: add corners
        step(511, 1,    1'b0, 1'b0, 1'b1, 1'b0, "R4");
        step(1023, 1023, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        step(512, 512,  1'b0, 1'b0, 1'b1, 1'b0, "R4");
        step(100, 200,  1'b1, 1'b0, 1'b1, 1'b0, "R1");
        step(1023, 0,   1'b1, 1'b0, 1'b1, 1'b0, "R1");
        // R2: subtract corners with carry_in at both values
        step(0, 1,      1'b0, 1'b1, 1'b1, 1'b0, "R2");
        step(0, 1,      1'b1, 1'b1, 1'b1, 1'b0, "R2");
        step(512, 1,    1'b1, 1'b1, 1'b1, 1'b0, "R4");
        step(511, 1023, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        step(300, 300,  1'b1, 1'b1, 1'b1, 1'b0, "R3");
        // R8: mode flips every cycle
        step(700, 200,  1'b0, 1'b0, 1'b1, 1'b0, "R8");
        step(700, 200,  1'b0, 1'b1, 1'b1, 1'b0, "R8");
        step(700, 200,  1'b1, 1'b0, 1'b1, 1'b0, "R8");
        // R7: hold with enable low
        step(5, 6,      1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1000, 9,   1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R6: clear beats enable
        step(511, 511,  1'b1, 1'b0, 1'b1, 1'b1, "R6");
        step(3, 4,      1'b0, 1'b1, 1'b0, 1'b1, "R6");

        // R1 R2 R3 R4 R6 R7: random operands across all control combinations
        for (int i = 0; i < 1200; i++) begin
            int ctl;
            ctl = i % 16;
            step($urandom_range(MASK), $urandom_range(MASK),
                 ctl[0], ctl[1], (ctl[2] | ctl[3]), (ctl[3] & ctl[2] & ctl[0]),
                 ctl[1] ? "R2" : "R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule